// File: doc/BRIEF.md
# Parallel RGB Panel Sync Timing Generator

This block produces the raster timing for a parallel RGB panel, 480 visible columns by 272 visible rows at its defaults. A system clock is divided by a run-time divider input into a pixel clock with a period of 2*(div_i+1) system cycles. Inside the pixel clock, a column counter and a row counter sweep a full line and a full frame, blanking included. The block decodes those counters into an active-high line sync, an active-high frame sync, a data-enable window, and the column and row of the pixel being shown.

Every timing output changes only at a falling edge of the pixel clock, so the panel can latch on the rising edge. The window of active data is placed by delays counted from the leading edge of each sync. The frame sync lasts a whole number of lines, which is a whole number of pixel clocks. A pixel source uses `pix_en_o` as its advance strobe and `col_o`/`row_o` as its fetch address. Dropping `en_i` parks the raster at its origin. Raising it again starts a fresh frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `en_i` is low, and in the cycle after it is sampled low, every output (`pclk_o`, `pix_en_o`, `hsync_o`, `vsync_o`, `de_o`, `col_o`, `row_o`) is 0, whatever `div_i` does.
- R2: While enabled, `pclk_o` has a period of 2*(div_i+1) system cycles. It is low for the first div_i+1 cycles after enabling and high for the next div_i+1.
- R3: `pix_en_o` is high for exactly the one system cycle that precedes each falling edge of `pclk_o`. The sync, enable and position outputs change only on the edge that follows that cycle, or on enabling or disabling.
- R4: A line lasts H_TOTAL pixel slots. `hsync_o` is 1 in slots 0 to H_SYNC-1 of each line.
- R5: Columns are active in slots H_DELAY to H_DELAY+H_ACTIVE-1 of a line. In an active slot on an active row, `col_o` equals slot minus H_DELAY.
- R6: A frame lasts V_TOTAL lines. `vsync_o` is 1 for all slots of lines 0 to V_SYNC-1, which is V_SYNC*H_TOTAL pixel slots.
- R7: Rows are active in lines V_DELAY to V_DELAY+V_ACTIVE-1. In an active slot on an active row, `row_o` equals line minus V_DELAY.
- R8: `de_o` is 1 only when both the column and the row are active. Whenever `de_o` is 0, `col_o` and `row_o` are 0.
- R9: The first system cycle after `en_i` is sampled high is slot 0 of line 0, with `hsync_o` and `vsync_o` both 1. This holds for a restart in the middle of a frame too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low parks the raster at its origin |
| div_i | input | DIV_W | Pixel clock divider N, period 2*(N+1) |
| pclk_o | output | 1 | Pixel clock to the panel |
| pix_en_o | output | 1 | Strobe in the cycle before each pixel clock falling edge |
| hsync_o | output | 1 | Line sync, active high |
| vsync_o | output | 1 | Frame sync, active high |
| de_o | output | 1 | Data-enable window |
| col_o | output | $clog2(H_ACTIVE) | Active column, 0 outside the window |
| row_o | output | $clog2(V_ACTIVE) | Active row, 0 outside the window |

## Verification
The bench builds the block with a shrunken raster: a 12-slot line with 3 slots of sync, a delay of 4 and 5 active columns, and an 8-line frame with 2 lines of sync, a delay of 3 and 3 active rows. At this size, every line wrap, frame wrap, window edge and sync edge falls within a few hundred system cycles. The dividers used are 0, the value computed for an 8 MHz pixel clock from the 50 MHz bench clock (2), and 5. Together they cover the fastest pixel clock possible and two slower periods, and the raster is compared cycle by cycle over more than one full frame. A restart in the middle of a frame, with a new divider, shows that the raster returns to its origin.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

  typedef struct packed {
    logic sync;
    logic act;
  } axis_flags_t;

  // divider N for sys_hz / (2*(N+1)) ~= pix_hz
  function automatic int unsigned pix_div_calc(int unsigned sys_hz, int unsigned pix_hz);
    return ((sys_hz / pix_hz) / 2) - 1;
  endfunction

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             pclk_q;
  logic             half_done;

  // >= tolerates div_i shrinking mid-half-period
  assign half_done = (cnt_q >= div_i);
  assign fall_o    = run_i & half_done & pclk_q;
  assign pclk_o    = pclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else if (half_done) begin
      cnt_q  <= '0;
      pclk_q <= ~pclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr #(
  parameter int H_TOTAL = 525,
  parameter int V_TOTAL = 286,
  localparam int HW = $clog2(H_TOTAL + 1),
  localparam int VW = $clog2(V_TOTAL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_wrap;

  assign h_wrap = step_i & (h_q == H_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (clr_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (step_i) begin
      h_q <= h_wrap ? '0 : h_q + 1'b1;
      if (h_wrap) v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;
endmodule

// File: rtl/lcd_axis_dec.sv
module lcd_axis_dec
  import lcd_tim_pkg::*;
#(
  parameter int CW     = 10,
  parameter int SYNC_W = 41,
  parameter int DELAY  = 43,
  parameter int ACTIVE = 480,
  localparam int PW = $clog2(ACTIVE)
) (
  input  logic [CW-1:0] cnt_i,
  output axis_flags_t   flags_o,
  output logic [PW-1:0] pos_o
);
  localparam logic [CW-1:0] C_SYNC  = CW'(SYNC_W);
  localparam logic [CW-1:0] C_START = CW'(DELAY);
  localparam logic [CW-1:0] C_END   = CW'(DELAY + ACTIVE);

  logic [CW-1:0] off;

  assign off           = cnt_i - C_START;
  assign flags_o.sync  = (cnt_i < C_SYNC);
  assign flags_o.act   = (cnt_i >= C_START) && (cnt_i < C_END);
  assign pos_o         = flags_o.act ? off[PW-1:0] : '0;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tim_pkg::*;
#(
  parameter int H_TOTAL  = 525,
  parameter int H_SYNC   = 41,
  parameter int H_DELAY  = 43,
  parameter int H_ACTIVE = 480,
  parameter int V_TOTAL  = 286,
  parameter int V_SYNC   = 10,
  parameter int V_DELAY  = 12,
  parameter int V_ACTIVE = 272,
  parameter int DIV_W    = 16,
  localparam int COL_W = $clog2(H_ACTIVE),
  localparam int ROW_W = $clog2(V_ACTIVE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pclk_o,
  output logic             pix_en_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int HW = $clog2(H_TOTAL + 1);
  localparam int VW = $clog2(V_TOTAL + 1);

  logic             run_q;
  logic             cnt_run;
  logic             fall;
  logic [HW-1:0]    h_cnt;
  logic [VW-1:0]    v_cnt;
  axis_flags_t      h_fl, v_fl;
  logic [COL_W-1:0] h_pos;
  logic [ROW_W-1:0] v_pos;
  logic             de;

  // one cycle of hold at origin after en rises: slot 0 gets a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  assign cnt_run = en_i & run_q;

  lcd_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (cnt_run),
    .div_i  (div_i),
    .pclk_o (pclk_o),
    .fall_o (fall)
  );

  lcd_scan_ctr #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_i),
    .step_i (fall),
    .h_o    (h_cnt),
    .v_o    (v_cnt)
  );

  lcd_axis_dec #(.CW(HW), .SYNC_W(H_SYNC), .DELAY(H_DELAY), .ACTIVE(H_ACTIVE)) u_hdec (
    .cnt_i   (h_cnt),
    .flags_o (h_fl),
    .pos_o   (h_pos)
  );

  lcd_axis_dec #(.CW(VW), .SYNC_W(V_SYNC), .DELAY(V_DELAY), .ACTIVE(V_ACTIVE)) u_vdec (
    .cnt_i   (v_cnt),
    .flags_o (v_fl),
    .pos_o   (v_pos)
  );

  assign de       = run_q & h_fl.act & v_fl.act;
  assign pix_en_o = fall;
  assign hsync_o  = run_q & h_fl.sync;
  assign vsync_o  = run_q & v_fl.sync;
  assign de_o     = de;
  assign col_o    = de ? h_pos : '0;
  assign row_o    = de ? v_pos : '0;
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk #(
  parameter int COL_W = 9,
  parameter int ROW_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pclk_o,
  input logic             pix_en_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input logic [COL_W-1:0] col_o,
  input logic [ROW_W-1:0] row_o
);
  // R1
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pclk_o && !pix_en_o && !hsync_o && !vsync_o && !de_o));

  // R3
  strobe_high_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |-> pclk_o);

  // R2
  strobe_then_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && en_i) |=> !pclk_o);

  // R3
  outputs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(en_i, 2) && !$past(pix_en_o))
      |-> ($stable(hsync_o) && $stable(vsync_o) && $stable(de_o)));

  // R8
  pos_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (col_o == '0 && row_o == '0));

  // R9
  frame_starts_with_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> hsync_o);
endmodule

bind lcd_timing_gen lcd_timing_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .pclk_o   (pclk_o),
  .pix_en_o (pix_en_o),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .de_o     (de_o),
  .col_o    (col_o),
  .row_o    (row_o)
);

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;
  import lcd_tim_pkg::*;

  localparam int HT = 12, HS = 3, HD = 4, HA = 5;
  localparam int VT = 8,  VS = 2, VD = 3, VA = 3;
  localparam int DW = 16;
  localparam int CW = $clog2(HA);
  localparam int RW = $clog2(VA);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [DW-1:0] div = '0;
  logic          pclk, pix_en, hs, vs, de;
  logic [CW-1:0] col;
  logic [RW-1:0] row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lcd_timing_gen #(
    .H_TOTAL(HT), .H_SYNC(HS), .H_DELAY(HD), .H_ACTIVE(HA),
    .V_TOTAL(VT), .V_SYNC(VS), .V_DELAY(VD), .V_ACTIVE(VA), .DIV_W(DW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div),
    .pclk_o(pclk), .pix_en_o(pix_en), .hsync_o(hs), .vsync_o(vs),
    .de_o(de), .col_o(col), .row_o(row)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "pclk", int'(pclk), 0);
    chk(req, "pix_en", int'(pix_en), 0);
    chk(req, "hsync", int'(hs), 0);
    chk(req, "vsync", int'(vs), 0);
    chk(req, "de", int'(de), 0);
    chk(req, "col", int'(col), 0);
    chk(req, "row", int'(row), 0);
  endtask

  // R1: reset and disabled state
  task automatic t_reset();
    @(negedge clk);
    chk_quiet("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      div = DW'(i % 3);
    end
    chk_quiet("R1");
  endtask

  // enable at a negedge, then compare every cycle against the raster model
  task automatic t_run(input int d, input int ncyc, input string tag);
    int p, ph, s, h, v, bad;
    bit ha, va, de_e;
    div = DW'(d);
    p = 2 * (d + 1);
    bad = 0;
    @(negedge clk);
    en = 1'b1;
    for (int n = 0; n < ncyc && bad < 3; n++) begin
      @(posedge clk);
      @(negedge clk);
      ph = n % p;
      s  = n / p;
      h  = s % HT;
      v  = (s / HT) % VT;
      ha = (h >= HD) && (h < HD + HA);
      va = (v >= VD) && (v < VD + VA);
      de_e = ha && va;
      if (n == 0) begin
        chk("R9", {tag, " start hsync"}, int'(hs), 1);
        chk("R9", {tag, " start vsync"}, int'(vs), 1);
      end
      if (pclk    != (ph >= d + 1)) bad++;
      chk("R2", {tag, " pclk"}, int'(pclk), int'(ph >= d + 1));
      if (pix_en  != (ph == p - 1)) bad++;
      chk("R3", {tag, " pix_en"}, int'(pix_en), int'(ph == p - 1));
      if (hs != (h < HS)) bad++;
      chk("R4", {tag, " hsync"}, int'(hs), int'(h < HS));
      if (vs != (v < VS)) bad++;
      chk("R6", {tag, " vsync"}, int'(vs), int'(v < VS));
      if (de != de_e) bad++;
      chk("R8", {tag, " de"}, int'(de), int'(de_e));
      chk("R5", {tag, " col"}, int'(col), de_e ? h - HD : 0);
      chk("R7", {tag, " row"}, int'(row), de_e ? v - VD : 0);
    end
  endtask

  // R1 + R9: stop mid-frame, outputs drop, restart from origin
  task automatic t_stop();
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_quiet("R1");
    for (int i = 0; i < 7; i++) @(negedge clk);
    chk_quiet("R1");
  endtask

  initial begin
    t_reset();
    t_run(0, 2 * 2 * HT * VT + 10, "div0");
    t_stop();
    t_run(int'(pix_div_calc(50_000_000, 8_000_000)), 6 * HT * VT + 100, "div8mhz");
    t_stop();
    t_run(5, 12 * HT * VT + 30, "div5");
    t_stop();
    t_run(1, 4 * HT * 3, "restart");
    t_stop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule